// File: doc/BRIEF.md
# GF(2^8) Dual-Weight Parity Generator

This block forms storage-array parity across a group of equal-length byte streams. Every source contributes one input beat per stripe position. A beat carries `LANES` bytes. The beats of one stripe position arrive back to back in source order, so beat k of a group belongs to source k. Each byte lane has its own accumulators. When the group's final beat is accepted, the block produces one output beat that carries two sums: a plain XOR of all sources (P), and a sum over GF(2^8) of each source byte times its own 8-bit weight (Q).

The operation is set by static inputs that must not change while a group is in flight:
- the source count, stored as count minus one;
- a dual/single selector;
- a continuation flag;
- the vector of per-source weights;
- the low eight bits of the reduction polynomial (x^8 is implied; 0x1D is the usual value).

In continuation mode the caller appends earlier results as extra beats after the sources, and the block weights those beats itself. A request with one source is served by sending that source twice; the block gives the second copy weight 0 and returns only Q.

Top module: `gfp_parity_gen`

## Requirements
- R1: In dual mode (`cfg_dual`=1 and more than one source), each byte of `out_p` equals the XOR of the same byte lane over every beat of the group.
- R2: Each byte of `out_q` equals the GF(2^8) sum of beat k's byte times weight k, where weight k is `coef_vec[8k+7:8k]`. Multiplication is reduced by x^8 + `poly_low`.
- R3: `cfg_count_m1` holds the source count minus one (values 1..15 give 2..16 sources), and a group without continuation is exactly that many beats long.
- R4: With `cfg_count_m1`=0, a group is two beats (the same source sent twice). `out_q` is weight 0 times the first beat, `out_p` is zero, and single-output behaviour is forced even when `cfg_dual`=1.
- R5: In single mode (`cfg_dual`=0), `out_q` carries the weighted sum and `out_p` is zero.
- R6: In single mode with `cfg_cont`=1, one extra beat (the previous result) follows the sources with weight 1.
- R7: In dual mode with `cfg_cont`=1, three extra beats follow the sources (old P, old Q, old Q). All three enter the XOR for P. Their Q weights are 0, 0 and 1, in that order.
- R8: `out_valid` rises in the cycle after the group's final beat is accepted, and `out_last` copies `in_last` of that final beat.
- R9: While `out_valid`=1 and `out_ready`=0, the outputs hold stable and `in_ready` is low.
- R10: During and right after synchronous reset, `out_valid` is low and `in_ready` is high.
- R11: Changing `poly_low` changes the field reduction used for Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_low | input | 8 | Reduction polynomial without the x^8 term |
| cfg_count_m1 | input | 4 | Source count minus one |
| cfg_dual | input | 1 | 1: P and Q; 0: weighted sum only |
| cfg_cont | input | 1 | Continuation: earlier results follow the sources |
| coef_vec | input | 128 | Per-source Q weights, source k at bits 8k+7:8k |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 32 | One beat of one source, LANES bytes |
| in_last | input | 1 | Marks the final group of a block |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result consumer ready |
| out_p | output | 32 | XOR parity per lane |
| out_q | output | 32 | Weighted parity per lane |
| out_last | output | 1 | Final result beat of the block |

## Verification
Groups of random bytes with random weights are driven in dual mode at several source counts, up to the 16-source maximum. Comparing P against Q separates the plain XOR path from the multiplier path, and each source position gets its own weight. Single mode, the one-source case and both continuation modes use group lengths that differ from the count field, so a wrong beat count or a wrong weight for an appended beat shows up as a P or Q mismatch. A second polynomial shows whether the field reduction follows `poly_low`. Random and forced output stalls show whether results are held and the input is blocked while a result waits.

// File: rtl/gfp_pkg.sv
package gfp_pkg;
  typedef logic [7:0] gf_byte_t;

  typedef struct packed {
    logic     first;
    logic     final_beat;
    gf_byte_t q_weight;
  } beat_info_t;
endpackage

// File: rtl/gfp_gf_mul.sv
module gfp_gf_mul
  import gfp_pkg::*;
(
  input  gf_byte_t a,
  input  gf_byte_t b,
  input  gf_byte_t poly,
  output gf_byte_t y
);
  gf_byte_t r;

  // MSB-first shift and conditional reduce, eight steps
  always_comb begin
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? poly : 8'h00);
      if (b[i]) r = r ^ a;
    end
  end

  assign y = r;
endmodule

// File: rtl/gfp_seq.sv
module gfp_seq
  import gfp_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = $clog2(MAX_SRC),
  parameter int IDX_W   = $clog2(MAX_SRC + 4)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [CNT_W-1:0]   cnt_m1,
  input  logic               dual_req,
  input  logic               cont,
  input  logic [MAX_SRC*8-1:0] coef_vec,
  output beat_info_t         info,
  output logic               dual_eff
);
  gf_byte_t         coef_arr [MAX_SRC];
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] n_src, eff_n, extra, total, ext_pos;
  logic             one_src;

  for (genvar k = 0; k < MAX_SRC; k++) begin : g_coef
    assign coef_arr[k] = coef_vec[k*8 +: 8];
  end

  always_comb begin
    n_src    = IDX_W'(cnt_m1) + IDX_W'(1);
    one_src  = (cnt_m1 == '0);
    eff_n    = one_src ? IDX_W'(2) : n_src;
    dual_eff = dual_req & ~one_src;
    extra    = cont ? (dual_eff ? IDX_W'(3) : IDX_W'(1)) : '0;
    total    = eff_n + extra;
    ext_pos  = idx - eff_n;

    info.first      = (idx == '0);
    info.final_beat = (idx == total - IDX_W'(1));
    if (idx < eff_n) begin
      if (one_src && idx == IDX_W'(1)) info.q_weight = 8'h00;
      else                             info.q_weight = coef_arr[idx[CNT_W-1:0]];
    end else if (dual_eff) begin
      info.q_weight = (ext_pos == IDX_W'(2)) ? 8'h01 : 8'h00;
    end else begin
      info.q_weight = 8'h01;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         idx <= '0;
    else if (accept) idx <= info.final_beat ? '0 : idx + IDX_W'(1);
  end
endmodule

// File: rtl/gfp_lane.sv
module gfp_lane
  import gfp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  logic     first,
  input  logic     final_beat,
  input  logic     dual_eff,
  input  gf_byte_t poly,
  input  gf_byte_t weight,
  input  gf_byte_t din,
  output gf_byte_t p_out,
  output gf_byte_t q_out
);
  gf_byte_t acc_p, acc_q, prod, nxt_p, nxt_q;

  gfp_gf_mul u_mul (.a(din), .b(weight), .poly(poly), .y(prod));

  assign nxt_p = first ? din  : (acc_p ^ din);
  assign nxt_q = first ? prod : (acc_q ^ prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_p <= '0;
      acc_q <= '0;
      p_out <= '0;
      q_out <= '0;
    end else if (accept) begin
      acc_p <= nxt_p;
      acc_q <= nxt_q;
      if (final_beat) begin
        p_out <= dual_eff ? nxt_p : 8'h00;
        q_out <= nxt_q;
      end
    end
  end
endmodule

// File: rtl/gfp_parity_gen.sv
module gfp_parity_gen
  import gfp_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_SRC = 16,
  localparam int CNT_W  = $clog2(MAX_SRC),
  localparam int DW     = LANES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           poly_low,
  input  logic [CNT_W-1:0]     cfg_count_m1,
  input  logic                 cfg_dual,
  input  logic                 cfg_cont,
  input  logic [MAX_SRC*8-1:0] coef_vec,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_p,
  output logic [DW-1:0]        out_q,
  output logic                 out_last
);
  beat_info_t info;
  logic       dual_eff;
  logic       accept;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  gfp_seq #(.MAX_SRC(MAX_SRC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .cnt_m1(cfg_count_m1),
    .dual_req(cfg_dual), .cont(cfg_cont), .coef_vec(coef_vec),
    .info(info), .dual_eff(dual_eff)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gfp_lane u_lane (
      .clk(clk), .rst(rst), .accept(accept), .first(info.first),
      .final_beat(info.final_beat), .dual_eff(dual_eff), .poly(poly_low),
      .weight(info.q_weight), .din(in_data[l*8 +: 8]),
      .p_out(out_p[l*8 +: 8]), .q_out(out_q[l*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (accept && info.final_beat) begin
      out_valid <= 1'b1;
      out_last  <= in_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gfp_checker.sv
module gfp_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_p,
  input logic [DW-1:0] out_q,
  input logic          out_last
);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_q) && $stable(out_last));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_result_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

bind gfp_parity_gen gfp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p),
  .out_q(out_q), .out_last(out_last)
);

// File: tb/gfp_parity_gen_test.sv
`timescale 1ns/1ps
module gfp_parity_gen_test;
  localparam int LANES = 4;
  localparam int MAXS  = 16;
  localparam int DW    = LANES * 8;

  logic            clk = 0, rst = 1;
  logic [7:0]      poly_low = 8'h1D;
  logic [3:0]      cfg_count_m1 = '0;
  logic            cfg_dual = 0, cfg_cont = 0;
  logic [MAXS*8-1:0] coef_vec = '0;
  logic            in_valid = 0, in_last = 0, out_ready = 1;
  logic [DW-1:0]   in_data = '0;
  logic            in_ready, out_valid, out_last;
  logic [DW-1:0]   out_p, out_q;

  typedef struct { logic [DW-1:0] p, q; logic last; string req; } exp_t;
  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0, cyc = 0, stall_mode = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  gfp_parity_gen uut (.*);

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b, logic [7:0] poly);
    logic [7:0] x = a, acc = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = x[7] ? ({x[6:0], 1'b0} ^ poly) : {x[6:0], 1'b0};
    end
    return acc;
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: one group, expected pushed to the scoreboard
  task automatic run_group(int n, bit dual, bit cont, bit last, string req);
    logic [DW-1:0] beats [MAXS+3];
    logic [7:0] w [MAXS+3];
    int effn, total, ext;
    bit deff;
    exp_t e;
    effn = (n == 1) ? 2 : n;
    deff = dual && (n > 1);
    ext  = cont ? (deff ? 3 : 1) : 0;
    total = effn + ext;
    @(negedge clk);
    cfg_count_m1 = 4'(n - 1); cfg_dual = dual; cfg_cont = cont;
    for (int k = 0; k < total; k++) begin
      beats[k] = $urandom;
      if (k < effn) w[k] = (n == 1 && k == 1) ? 8'h00 : coef_vec[k*8 +: 8];
      else if (deff) w[k] = (k - effn == 2) ? 8'h01 : 8'h00;
      else w[k] = 8'h01;
    end
    if (n == 1) beats[1] = beats[0];
    e.p = '0; e.q = '0; e.last = last; e.req = req;
    for (int k = 0; k < total; k++)
      for (int l = 0; l < LANES; l++) begin
        e.p[l*8 +: 8] ^= beats[k][l*8 +: 8];
        e.q[l*8 +: 8] ^= ref_mul(beats[k][l*8 +: 8], w[k], poly_low);
      end
    if (!deff) e.p = '0;
    exp_q.push_back(e);
    for (int k = 0; k < total; k++) begin
      in_valid = 1; in_data = beats[k]; in_last = last;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic new_coefs;
    for (int k = 0; k < MAXS; k++) coef_vec[k*8 +: 8] = 8'($urandom);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (stall_mode == 2) ? 1'b0 :
                  (stall_mode == 1) ? (($urandom % 3) != 0) : 1'b1;
      #2;
      if (!rst && out_valid && out_ready) begin
        exp_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8 unexpected result p=%h q=%h expected none", out_p, out_q);
        end else begin
          e = exp_q.pop_front();
          if (out_p !== e.p || out_q !== e.q || out_last !== e.last) begin
            n_bad++;
            $display("FAIL %s p=%h/%h q=%h/%h last=%b/%b (actual/expected)",
                     e.req, out_p, e.p, out_q, e.q, out_last, e.last);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        report();
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
    end
    rst = 0;

    new_coefs();
    for (int g = 0; g < 3; g++) run_group(4, 1, 0, g == 2, "R1 R2 dual n=4");
    new_coefs();
    for (int g = 0; g < 2; g++) run_group(16, 1, 0, g == 1, "R3 dual n=16");
    run_group(2, 1, 0, 1, "R3 dual n=2");
    new_coefs();
    for (int g = 0; g < 2; g++) run_group(3, 0, 0, g == 1, "R5 single n=3");
    run_group(1, 1, 0, 1, "R4 one source dual requested");
    run_group(1, 0, 0, 0, "R4 one source single");
    new_coefs();
    for (int g = 0; g < 2; g++) run_group(2, 0, 1, g == 1, "R6 single continuation");
    for (int g = 0; g < 2; g++) run_group(3, 1, 1, g == 1, "R7 dual continuation");
    poly_low = 8'h2B;
    for (int g = 0; g < 2; g++) run_group(5, 1, 0, g == 1, "R11 poly 0x2B");
    poly_low = 8'h1D;
    stall_mode = 1;
    new_coefs();
    for (int g = 0; g < 6; g++) run_group(2 + g, g[0], g == 3, g == 5, "R8 random stall");
    repeat (20) @(negedge clk);

    // R9: forced stall holds result and blocks input
    stall_mode = 2;
    run_group(3, 1, 0, 1, "R9 held result");
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b1 || in_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 out_valid=%b in_ready=%b expected 1/0", out_valid, in_ready);
    end
    stall_mode = 0;
    repeat (10) @(negedge clk);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 pending results=%0d expected 0", exp_q.size());
    end
    done = 1;
    report();
  end
endmodule